// File: doc/BRIEF.md
# SCSI Controller Command Decoder

This block sits behind the command register of a SCSI protocol controller. Each time the host writes a command byte, the decoder interprets it and in the next cycle updates the controller's interrupt-cause, sequence-step and phase-status registers. It also maintains the DMA-mode flag and the live transfer counter, and issues one-cycle start strobes to the transfer and selection engines, which lie outside this block. Bus timing and data movement are handled elsewhere. Only the register bookkeeping that a command implies is done here.

Bit 7 of the command byte chooses DMA or programmed mode. When DMA is chosen, the live counter is reloaded from the count bytes the host staged earlier. Bits 6..0 hold the opcode. Every known opcode writes its own fixed set of register values. A configuration bit can keep a bus reset from interrupting the host. An opcode outside the known set is rejected as a whole and raises a one-cycle error strobe.

All inputs are plain control pins. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure: a command strobe is accepted on every clock edge where it is high.

Top module: `scmd_decoder`

## Requirements
- R1: A known opcode with command bit 7 set makes `dma_mode` 1 and loads `live_cnt` with `stage_cnt`. The exception is chip reset (opcode 0x02).
- R2: A known opcode with bit 7 clear makes `dma_mode` 0 and leaves `live_cnt` unchanged.
- R3: Flush (opcode 0x01) sets `int_cause` = 0x08 and `seq_step` = 0, and pulses `flags_clr`.
- R4: After `rst_n` is released, and after chip reset (opcode 0x02), every register output is 0 and `irq` is low. Chip reset also pulses `chip_rst`.
- R5: Bus reset (opcode 0x03) sets `int_cause` = 0x80. It raises `irq` only when bit 6 of `cfg_reg` is 0. When that bit is 1, `irq` keeps its previous value.
- R6: Message accepted (opcode 0x12) sets `int_cause` = 0x20, `seq_step` = 0 and `irq`, and pulses `flags_clr`.
- R7: Transfer pad (opcode 0x18) sets `status` = 0x10, `int_cause` = 0x08 and `seq_step` = 0, and leaves `irq` unchanged.
- R8: A selection opcode (0x41, 0x42 or 0x43) issued while `tgt_present` is 0 sets `status` = 0, `int_cause` = 0x20, `seq_step` = 0 and `irq`, and gives no `sel_go`.
- R9: Opcodes 0x41 and 0x42 issued while `tgt_present` is 1 pulse `sel_go` and leave the register outputs unchanged.
- R10: Opcode 0x43 issued while `tgt_present` is 1 sets `status` = 0x12, `int_cause` = 0x18, `seq_step` = 4, `cmd_capture` and `irq`, and pulses `sel_go`.
- R11: Enable selection (opcode 0x44) clears `int_cause`. Set ATN (0x1A) and no-op (0x00) change no register.
- R12: Transfer information (opcode 0x10) pulses `xfer_go` and clears `cmd_capture`.
- R13: Initiator complete (opcode 0x11) sets `int_cause` = 0x08 and `irq`. With bit 7 set it also writes `status` = 0x17 and `seq_step` = 4. With bit 7 clear it ORs 0x07 into `status`.
- R14: Any other opcode pulses `bad_op` and leaves every register output, including `dma_mode` and `live_cnt`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_byte | input | 8 | Command byte: bit 7 selects DMA, bits 6..0 hold the opcode |
| stage_cnt | input | 16 | Transfer count staged by the host (mid byte above low byte) |
| cfg_reg | input | 8 | Configuration register; bit 6 silences the bus-reset interrupt |
| tgt_present | input | 1 | The addressed target exists |
| dma_mode | output | 1 | DMA mode flag |
| live_cnt | output | 16 | Live transfer counter |
| int_cause | output | 8 | Interrupt-cause register |
| seq_step | output | 3 | Sequence-step register |
| status | output | 8 | Phase/status register |
| cmd_capture | output | 1 | Command-capture mode |
| irq | output | 1 | Interrupt request |
| flags_clr | output | 1 | One-cycle pulse that clears the FIFO flags |
| chip_rst | output | 1 | One-cycle chip reset pulse |
| xfer_go | output | 1 | One-cycle transfer start strobe |
| sel_go | output | 1 | One-cycle selection start strobe |
| bad_op | output | 1 | One-cycle unknown-opcode strobe |

## Verification
Every result of a command is due exactly one clock edge after the edge that samples `cmd_valid`. Register outputs change on that edge, and the strobes are high only for the cycle that follows it. The bench drives each command at a falling edge, releases it at the next falling edge, and checks all outputs there, half a cycle after the single updating edge. This catches both a missing update and a strobe that lasts more than one cycle. Before each table vector the bench issues a chip reset through the command interface, so each vector's expected values can be computed from the reset state alone.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  localparam int DATA_W = 8;
  localparam int SEQ_W  = 3;

  typedef enum logic [6:0] {
    OP_NOP     = 7'h00,
    OP_FLUSH   = 7'h01,
    OP_CHIPRST = 7'h02,
    OP_BUSRST  = 7'h03,
    OP_XFER    = 7'h10,
    OP_CMPLT   = 7'h11,
    OP_MSGOK   = 7'h12,
    OP_PAD     = 7'h18,
    OP_ATN     = 7'h1A,
    OP_SEL     = 7'h41,
    OP_SELA    = 7'h42,
    OP_SELAS   = 7'h43,
    OP_ENSEL   = 7'h44
  } op_e;

  typedef struct packed {
    logic nop;
    logic flush;
    logic chiprst;
    logic busrst;
    logic xfer;
    logic cmplt;
    logic msgok;
    logic pad;
    logic atn;
    logic sel;
    logic sela;
    logic selas;
    logic ensel;
    logic bad;
  } op_hot_t;

  localparam logic [DATA_W-1:0] INT_FC   = 8'h08;
  localparam logic [DATA_W-1:0] INT_BS   = 8'h10;
  localparam logic [DATA_W-1:0] INT_DC   = 8'h20;
  localparam logic [DATA_W-1:0] INT_RST  = 8'h80;
  localparam logic [DATA_W-1:0] ST_TC    = 8'h10;
  localparam logic [DATA_W-1:0] ST_CMD   = 8'h02;
  localparam logic [DATA_W-1:0] ST_MSGIN = 8'h07;
  localparam logic [SEQ_W-1:0]  SEQ_CMD  = 3'd4;
endpackage

// File: rtl/scmd_opdec.sv
module scmd_opdec
  import scmd_pkg::*;
(
  input  logic [6:0] op,
  output op_hot_t    hot
);
  always_comb begin
    hot = '0;
    case (op)
      OP_NOP:     hot.nop     = 1'b1;
      OP_FLUSH:   hot.flush   = 1'b1;
      OP_CHIPRST: hot.chiprst = 1'b1;
      OP_BUSRST:  hot.busrst  = 1'b1;
      OP_XFER:    hot.xfer    = 1'b1;
      OP_CMPLT:   hot.cmplt   = 1'b1;
      OP_MSGOK:   hot.msgok   = 1'b1;
      OP_PAD:     hot.pad     = 1'b1;
      OP_ATN:     hot.atn     = 1'b1;
      OP_SEL:     hot.sel     = 1'b1;
      OP_SELA:    hot.sela    = 1'b1;
      OP_SELAS:   hot.selas   = 1'b1;
      OP_ENSEL:   hot.ensel   = 1'b1;
      default:    hot.bad     = 1'b1;
    endcase
  end
endmodule

// File: rtl/scmd_cnt_reload.sv
module scmd_cnt_reload #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int CNT_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             clr,
  input  logic             dma_bit,
  input  logic [CNT_W-1:0] stage,
  output logic             dma_mode,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dma_mode <= 1'b0;
    else if (clr) dma_mode <= 1'b0;
    else if (upd) dma_mode <= dma_bit;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g*LANE_W +: LANE_W] <= '0;
      else if (clr)
        cnt[g*LANE_W +: LANE_W] <= '0;
      else if (upd && dma_bit)
        cnt[g*LANE_W +: LANE_W] <= stage[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/scmd_regs.sv
module scmd_regs
  import scmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  op_hot_t           hot,
  input  logic              dma_bit,
  input  logic              tgt,
  input  logic              quiet,
  output logic [DATA_W-1:0] int_cause,
  output logic [SEQ_W-1:0]  seq_step,
  output logic [DATA_W-1:0] status,
  output logic              capture,
  output logic              irq
);
  logic any_sel;
  assign any_sel = hot.sel | hot.sela | hot.selas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_cause <= '0;
      seq_step  <= '0;
      status    <= '0;
      capture   <= 1'b0;
      irq       <= 1'b0;
    end else if (go) begin
      if (hot.chiprst) begin
        int_cause <= '0;
        seq_step  <= '0;
        status    <= '0;
        capture   <= 1'b0;
        irq       <= 1'b0;
      end else if (hot.flush) begin
        int_cause <= INT_FC;
        seq_step  <= '0;
      end else if (hot.busrst) begin
        int_cause <= INT_RST;
        if (!quiet) irq <= 1'b1;
      end else if (hot.xfer) begin
        capture <= 1'b0;
      end else if (hot.cmplt) begin
        int_cause <= INT_FC;
        irq       <= 1'b1;
        if (dma_bit) begin
          status   <= ST_TC | ST_MSGIN;
          seq_step <= SEQ_CMD;
        end else begin
          status <= status | ST_MSGIN;
        end
      end else if (hot.msgok) begin
        int_cause <= INT_DC;
        seq_step  <= '0;
        irq       <= 1'b1;
      end else if (hot.pad) begin
        status    <= ST_TC;
        int_cause <= INT_FC;
        seq_step  <= '0;
      end else if (any_sel && !tgt) begin
        status    <= '0;
        int_cause <= INT_DC;
        seq_step  <= '0;
        irq       <= 1'b1;
      end else if (hot.selas) begin
        status    <= ST_TC | ST_CMD;
        int_cause <= INT_BS | INT_FC;
        seq_step  <= SEQ_CMD;
        capture   <= 1'b1;
        irq       <= 1'b1;
      end else if (hot.ensel) begin
        int_cause <= '0;
      end
    end
  end
endmodule

// File: rtl/scmd_decoder.sv
module scmd_decoder
  import scmd_pkg::*;
#(
  parameter int CNT_LANES = 2,
  parameter int QUIET_BIT = 6,
  localparam int CNT_W = DATA_W * CNT_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic [CNT_W-1:0]  stage_cnt,
  input  logic [DATA_W-1:0] cfg_reg,
  input  logic              tgt_present,
  output logic              dma_mode,
  output logic [CNT_W-1:0]  live_cnt,
  output logic [DATA_W-1:0] int_cause,
  output logic [SEQ_W-1:0]  seq_step,
  output logic [DATA_W-1:0] status,
  output logic              cmd_capture,
  output logic              irq,
  output logic              flags_clr,
  output logic              chip_rst,
  output logic              xfer_go,
  output logic              sel_go,
  output logic              bad_op
);
  op_hot_t hot;
  logic    accept;
  logic    soft_clr;

  scmd_opdec u_dec (
    .op  (cmd_byte[6:0]),
    .hot (hot)
  );

  assign accept   = cmd_valid & ~hot.bad;
  assign soft_clr = cmd_valid & hot.chiprst;

  scmd_cnt_reload #(.LANE_W(DATA_W), .LANES(CNT_LANES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (accept),
    .clr      (soft_clr),
    .dma_bit  (cmd_byte[7]),
    .stage    (stage_cnt),
    .dma_mode (dma_mode),
    .cnt      (live_cnt)
  );

  scmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (cmd_valid),
    .hot       (hot),
    .dma_bit   (cmd_byte[7]),
    .tgt       (tgt_present),
    .quiet     (cfg_reg[QUIET_BIT]),
    .int_cause (int_cause),
    .seq_step  (seq_step),
    .status    (status),
    .capture   (cmd_capture),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_clr <= 1'b0;
      chip_rst  <= 1'b0;
      xfer_go   <= 1'b0;
      sel_go    <= 1'b0;
      bad_op    <= 1'b0;
    end else begin
      flags_clr <= cmd_valid & (hot.flush | hot.msgok);
      chip_rst  <= soft_clr;
      xfer_go   <= cmd_valid & hot.xfer;
      sel_go    <= cmd_valid & tgt_present & (hot.sel | hot.sela | hot.selas);
      bad_op    <= cmd_valid & hot.bad;
    end
  end
endmodule

// File: rtl/scmd_decoder_chk.sv
module scmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_byte,
  input logic [15:0] stage_cnt,
  input logic [7:0]  cfg_reg,
  input logic        dma_mode,
  input logic [15:0] live_cnt,
  input logic [7:0]  int_cause,
  input logic [2:0]  seq_step,
  input logic [7:0]  status,
  input logic        irq,
  input logic        flags_clr,
  input logic        chip_rst,
  input logic        xfer_go,
  input logic        sel_go,
  input logic        bad_op
);
  logic [6:0] op;
  logic       known;
  assign op = cmd_byte[6:0];
  assign known = (op inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12,
                             7'h18, 7'h1A, 7'h41, 7'h42, 7'h43, 7'h44});

  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && known && op != 7'h02 && cmd_byte[7]
    |=> dma_mode && live_cnt == $past(stage_cnt));

  p_pio_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && known && op != 7'h02 && !cmd_byte[7]
    |=> !dma_mode && $stable(live_cnt));

  p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 7'h01 |=> int_cause == 8'h08 && seq_step == 3'd0 && flags_clr);

  p_chiprst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 7'h02 |=> chip_rst && !irq && status == 8'h00 && !dma_mode);

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 7'h03 && cfg_reg[6] && !irq |=> !irq && int_cause == 8'h80);

  p_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 7'h18 |=> status == 8'h10 && irq == $past(irq));

  p_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_go, xfer_go, chip_rst, bad_op}));

  p_bad_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !known |=> bad_op && $stable(int_cause) && $stable(status)
                            && $stable(live_cnt) && $stable(dma_mode) && $stable(irq));
endmodule

bind scmd_decoder scmd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .stage_cnt (stage_cnt),
  .cfg_reg   (cfg_reg),
  .dma_mode  (dma_mode),
  .live_cnt  (live_cnt),
  .int_cause (int_cause),
  .seq_step  (seq_step),
  .status    (status),
  .irq       (irq),
  .flags_clr (flags_clr),
  .chip_rst  (chip_rst),
  .xfer_go   (xfer_go),
  .sel_go    (sel_go),
  .bad_op    (bad_op)
);

// File: tb/scmd_decoder_tb.sv
module scmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic [15:0] stage_cnt = '0;
  logic [7:0]  cfg_reg = '0;
  logic        tgt_present = 1'b0;
  logic        dma_mode, cmd_capture, irq, flags_clr, chip_rst, xfer_go, sel_go, bad_op;
  logic [15:0] live_cnt;
  logic [7:0]  int_cause, status;
  logic [2:0]  seq_step;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  scmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .stage_cnt(stage_cnt), .cfg_reg(cfg_reg), .tgt_present(tgt_present),
    .dma_mode(dma_mode), .live_cnt(live_cnt), .int_cause(int_cause),
    .seq_step(seq_step), .status(status), .cmd_capture(cmd_capture), .irq(irq),
    .flags_clr(flags_clr), .chip_rst(chip_rst), .xfer_go(xfer_go),
    .sel_go(sel_go), .bad_op(bad_op)
  );

  // {cmd[8], tgt, quiet, int[8], seq[3], status[8], irq, capture, {sel,xfer,flclr,bad}}
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b0, 8'h08, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0010}, // R3 flush
    {8'h03, 1'b0, 1'b0, 8'h80, 3'd0, 8'h00, 1'b1, 1'b0, 4'b0000}, // R5 loud
    {8'h03, 1'b0, 1'b1, 8'h80, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0000}, // R5 quiet
    {8'h12, 1'b0, 1'b0, 8'h20, 3'd0, 8'h00, 1'b1, 1'b0, 4'b0010}, // R6
    {8'h18, 1'b0, 1'b0, 8'h08, 3'd0, 8'h10, 1'b0, 1'b0, 4'b0000}, // R7
    {8'h41, 1'b0, 1'b0, 8'h20, 3'd0, 8'h00, 1'b1, 1'b0, 4'b0000}, // R8
    {8'hC3, 1'b0, 1'b0, 8'h20, 3'd0, 8'h00, 1'b1, 1'b0, 4'b0000}, // R8
    {8'h41, 1'b1, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 4'b1000}, // R9
    {8'h42, 1'b1, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 4'b1000}, // R9
    {8'h43, 1'b1, 1'b0, 8'h18, 3'd4, 8'h12, 1'b1, 1'b1, 4'b1000}, // R10
    {8'h44, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0000}, // R11
    {8'h1A, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0000}, // R11
    {8'h90, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0100}, // R12
    {8'h11, 1'b0, 1'b0, 8'h08, 3'd0, 8'h07, 1'b1, 1'b0, 4'b0000}, // R13 pio
    {8'h91, 1'b0, 1'b0, 8'h08, 3'd4, 8'h17, 1'b1, 1'b0, 4'b0000}, // R13 dma
    {8'h7F, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 4'b0001}  // R14
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge; the result is due after the next rising edge,
  // sampled at the falling edge that follows it
  task automatic send(input logic [7:0] c, input logic t, input logic q);
    @(negedge clk);
    cmd_byte = c; tgt_present = t; cfg_reg = {1'b0, q, 6'b0}; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset regs", {dma_mode, live_cnt, int_cause, status},  '0);
    chk("R4 reset irq", {irq, cmd_capture, seq_step}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      send(8'h02, 1'b0, 1'b0);
      chk("R4 chip_rst pulse", chip_rst, 1'b1);
      send(v[34:27], v[26], v[25]);
      chk($sformatf("vec%0d int_cause", i), int_cause, v[24:17]);
      chk($sformatf("vec%0d seq_step", i), seq_step, v[16:14]);
      chk($sformatf("vec%0d status", i), status, v[13:6]);
      chk($sformatf("vec%0d irq", i), irq, v[5]);
      chk($sformatf("vec%0d capture", i), cmd_capture, v[4]);
      chk($sformatf("vec%0d strobes", i), {sel_go, xfer_go, flags_clr, bad_op}, v[3:0]);
      @(negedge clk);
      chk($sformatf("vec%0d strobes one cycle", i), {sel_go, xfer_go, flags_clr, bad_op, chip_rst}, 5'b0);
    end

    // R1: DMA reload from staged count
    stage_cnt = 16'hA55A;
    send(8'h80, 1'b0, 1'b0);
    chk("R1 dma_mode", dma_mode, 1'b1);
    chk("R1 live_cnt", live_cnt, 16'hA55A);
    // R2: programmed mode keeps the counter
    stage_cnt = 16'h1234;
    send(8'h00, 1'b0, 1'b0);
    chk("R2 dma_mode", dma_mode, 1'b0);
    chk("R2 live_cnt", live_cnt, 16'hA55A);
    // R14: unknown opcode with bit 7 neither reloads nor sets DMA
    send(8'hFF, 1'b0, 1'b0);
    chk("R14 dma_mode", dma_mode, 1'b0);
    chk("R14 live_cnt", live_cnt, 16'hA55A);
    chk("R14 bad_op", bad_op, 1'b1);
    // R4: chip reset with bit 7 set clears counter and DMA mode
    send(8'h82, 1'b0, 1'b0);
    chk("R4 live_cnt clr", live_cnt, 16'h0);
    chk("R4 dma clr", dma_mode, 1'b0);

    // R12: capture mode cleared by transfer information
    send(8'h43, 1'b1, 1'b0);
    chk("R10 capture set", cmd_capture, 1'b1);
    send(8'h10, 1'b0, 1'b0);
    chk("R12 capture cleared", cmd_capture, 1'b0);
    chk("R12 xfer_go", xfer_go, 1'b1);
    // R7: pad keeps an already raised irq
    send(8'h18, 1'b0, 1'b0);
    chk("R7 irq kept high", irq, 1'b1);
    // R5: quiet bus reset keeps irq high
    send(8'h03, 1'b0, 1'b1);
    chk("R5 quiet keeps irq", irq, 1'b1);
    // R11: enable selection clears int_cause only
    send(8'h01, 1'b0, 1'b0);
    send(8'h44, 1'b0, 1'b0);
    chk("R11 int cleared", int_cause, 8'h00);
    chk("R11 status kept", status, 8'h10);
    // R11: no-op keeps everything
    send(8'h00, 1'b0, 1'b0);
    chk("R11 nop status", {status, int_cause, irq}, {8'h10, 8'h00, 1'b1});
    // R4: chip reset drops irq
    send(8'h02, 1'b0, 1'b0);
    chk("R4 irq dropped", irq, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule